// File: doc/BRIEF.md
# Windowed Register File Controller

This block holds the integer registers of a processor core whose procedure calls switch to a fresh group of registers instead of saving them to memory. Software sees 32 register numbers. Ten of them are global and shared by every procedure. The other 22 are remapped onto a circular physical file according to a current window pointer. Each window has sixteen registers of its own. A caller's six outgoing registers are the same storage as the callee's six incoming registers, so arguments and results pass without any copy.

A call strobe steps the current pointer down by one window and a return strobe steps it up by one, with wrap-around. A second pointer marks the oldest window still held on chip. When a call would reach that window, the block raises an overflow trap and leaves the pointer where it was. When a return would land on it, the block raises an underflow trap instead. A trap handler moves the oldest-window pointer with two step inputs, so it can spill one window to memory or refill one, and the trapped call or return can then be executed again.

There are two combinational read ports and one clocked write port, all addressed by register number. A read of a register that is being written in the same cycle returns the new data.

Top module: `rw_file`

## Requirements
- R1: Register number 0 always reads as zero, and a write to it has no effect.
- R2: Register numbers 1 to 9 name the same storage whatever the current window pointer is.
- R3: Register numbers 10 to 25 name storage private to the current window, so the same number in another window holds an independent value.
- R4: Register number 26+k (k = 0..5) in window w is the same storage as register number 10+k in window (w+1) mod NWIN, which means a callee sees its caller's registers 10..15 as its own 26..31.
- R5: A call that does not trap sets the current window pointer to (CWP−1) mod NWIN at the next clock edge. A return that does not trap sets it to (CWP+1) mod NWIN.
- R6: In a cycle with a call where (CWP−1) mod NWIN equals SWP, the overflow trap output is high in that same cycle and neither pointer changes.
- R7: In a cycle with a return and no call where (CWP+1) mod NWIN equals SWP, the underflow trap output is high in that same cycle and neither pointer changes.
- R8: Overflow is only raised in a cycle with a call, and underflow only in a cycle with a return. When call and return are both high, the call is acted on and the return is ignored.
- R9: In a cycle with neither call nor return, exactly one asserted step input moves SWP by one (increment up, decrement down, mod NWIN). The move is refused if SWP would then equal CWP. If both step inputs are high, or if a call or return is present, SWP holds.
- R10: When a read port addresses the same physical register as an enabled write (not register 0) in the same cycle, it returns the write data.
- R11: After reset, CWP is 0, SWP is 1 and both trap outputs are low while no strobe is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| swp_inc_i | input | 1 | Step the oldest-window pointer up (refill) |
| swp_dec_i | input | 1 | Step the oldest-window pointer down (spill) |
| rd_a_addr_i | input | 5 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 5 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write register number |
| wr_data_i | input | 32 | Write data |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Oldest resident window pointer |
| ovf_trap_o | output | 1 | Overflow trap, valid in the call cycle |
| unf_trap_o | output | 1 | Underflow trap, valid in the return cycle |

## Verification
The bench builds the block with its defaults: six windows, ten globals, six overlap registers and ten locals, which gives 106 physical registers. With only six windows, a few thousand mixed cycles of calls, returns, step inputs and register traffic drive both pointers through every reachable pair. That covers the trap conditions at each wrap position, refused SWP steps and collisions between call and return. A bench-side arithmetic map from register number and window to physical index predicts every read, including the caller/callee overlap at the wrap from window 5 to window 0.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int RW_XLEN  = 32;
  localparam int RW_NGLOB = 10;
  localparam int RW_NOUT  = 6;
  localparam int RW_NLOC  = 10;
  localparam int RW_NWIN  = 6;
endpackage

// File: rtl/rw_ptr_ctrl.sv
module rw_ptr_ctrl #(
  parameter int NWIN = 6,
  localparam int WPW = $clog2(NWIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           call_i,
  input  logic           ret_i,
  input  logic           swp_inc_i,
  input  logic           swp_dec_i,
  output logic [WPW-1:0] cwp_o,
  output logic [WPW-1:0] swp_o,
  output logic           ovf_o,
  output logic           unf_o
);
  localparam logic [WPW-1:0] TOP = WPW'(NWIN - 1);

  function automatic logic [WPW-1:0] wrap_inc(input logic [WPW-1:0] p);
    return (p == TOP) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [WPW-1:0] wrap_dec(input logic [WPW-1:0] p);
    return (p == '0) ? TOP : p - 1'b1;
  endfunction

  logic [WPW-1:0] cwp_q, cwp_d, swp_q, swp_d, swp_try;
  logic           cwp_en, swp_en, do_ret;

  always_comb begin
    do_ret  = ret_i && !call_i;
    ovf_o   = call_i && (wrap_dec(cwp_q) == swp_q);
    unf_o   = do_ret && (wrap_inc(cwp_q) == swp_q);
    cwp_en  = 1'b0;
    cwp_d   = cwp_q;
    if (call_i && !ovf_o) begin
      cwp_en = 1'b1;
      cwp_d  = wrap_dec(cwp_q);
    end else if (do_ret && !unf_o) begin
      cwp_en = 1'b1;
      cwp_d  = wrap_inc(cwp_q);
    end
    swp_try = swp_inc_i ? wrap_inc(swp_q) : wrap_dec(swp_q);
    swp_en  = !call_i && !ret_i && (swp_inc_i ^ swp_dec_i) && (swp_try != cwp_q);
    swp_d   = swp_try;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      swp_q <= WPW'(1);
    end else begin
      if (cwp_en) cwp_q <= cwp_d;
      if (swp_en) swp_q <= swp_d;
    end
  end

  assign cwp_o = cwp_q;
  assign swp_o = swp_q;

  AST_WINDOWS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_q != swp_q) else $error("pointers collided"); // R9
  AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ovf_o) |=> (cwp_q == wrap_dec($past(cwp_q)))) else $error("call step"); // R5
  AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && !unf_o) |=> (cwp_q == wrap_inc($past(cwp_q)))) else $error("ret step"); // R5
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ($stable(cwp_q) && $stable(swp_q))) else $error("ovf moved"); // R6
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |=> ($stable(cwp_q) && $stable(swp_q))) else $error("unf moved"); // R7
  AST_ONE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_o, unf_o})) else $error("two traps"); // R8
endmodule

// File: rtl/rw_addr_map.sv
module rw_addr_map #(
  parameter int NGLOB = 10,
  parameter int NOUT  = 6,
  parameter int NLOC  = 10,
  parameter int NWIN  = 6,
  localparam int WSZ  = NOUT + NLOC,
  localparam int NARCH = NGLOB + WSZ + NOUT,
  localparam int AAW  = $clog2(NARCH),
  localparam int WPW  = $clog2(NWIN),
  localparam int PAW  = $clog2(NGLOB + NWIN * WSZ)
) (
  input  logic [AAW-1:0] arch_i,
  input  logic [WPW-1:0] cwp_i,
  output logic [PAW-1:0] phys_o
);
  localparam int IN_BASE = NGLOB + WSZ;

  int a, w, off;

  always_comb begin
    a   = int'(arch_i);
    w   = int'(cwp_i);
    off = a - NGLOB;
    if (a >= IN_BASE) begin
      w   = (w == NWIN - 1) ? 0 : w + 1;
      off = a - IN_BASE;
    end
    if (a < NGLOB) phys_o = PAW'(a);
    else           phys_o = PAW'(NGLOB + w * WSZ + off);
  end
endmodule

// File: rtl/rw_store.sv
module rw_store #(
  parameter int XLEN  = 32,
  parameter int NPHYS = 106,
  parameter int NRD   = 2,
  localparam int PAW  = $clog2(NPHYS)
) (
  input  logic                clk,
  input  logic                we_i,
  input  logic [PAW-1:0]      waddr_i,
  input  logic [XLEN-1:0]     wdata_i,
  input  logic [NRD-1:0][PAW-1:0]  raddr_i,
  output logic [NRD-1:0][XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] mem [NPHYS];
  logic            wr_live;

  assign wr_live = we_i && (waddr_i != '0);

  always_ff @(posedge clk) begin
    if (wr_live) mem[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr_i[p] == '0)                     rdata_o[p] = '0;
      else if (wr_live && waddr_i == raddr_i[p]) rdata_o[p] = wdata_i;
      else                                      rdata_o[p] = mem[raddr_i[p]];
    end
  end
endmodule

// File: rtl/rw_file.sv
module rw_file
  import rw_pkg::*;
#(
  parameter int XLEN  = RW_XLEN,
  parameter int NGLOB = RW_NGLOB,
  parameter int NOUT  = RW_NOUT,
  parameter int NLOC  = RW_NLOC,
  parameter int NWIN  = RW_NWIN,
  localparam int WSZ   = NOUT + NLOC,
  localparam int NPHYS = NGLOB + NWIN * WSZ,
  localparam int AAW   = $clog2(NGLOB + WSZ + NOUT),
  localparam int WPW   = $clog2(NWIN),
  localparam int PAW   = $clog2(NPHYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            swp_inc_i,
  input  logic            swp_dec_i,
  input  logic [AAW-1:0]  rd_a_addr_i,
  output logic [XLEN-1:0] rd_a_data_o,
  input  logic [AAW-1:0]  rd_b_addr_i,
  output logic [XLEN-1:0] rd_b_data_o,
  input  logic            wr_en_i,
  input  logic [AAW-1:0]  wr_addr_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [WPW-1:0]  cwp_o,
  output logic [WPW-1:0]  swp_o,
  output logic            ovf_trap_o,
  output logic            unf_trap_o
);
  localparam int NPORT = 3;

  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [WPW-1:0] cwp;
  rw_ptr_ctrl #(.NWIN(NWIN)) u_ptr (
    .clk(clk), .rst_n(rst_s2), .call_i(call_i), .ret_i(ret_i),
    .swp_inc_i(swp_inc_i), .swp_dec_i(swp_dec_i),
    .cwp_o(cwp), .swp_o(swp_o), .ovf_o(ovf_trap_o), .unf_o(unf_trap_o)
  );
  assign cwp_o = cwp;

  logic [NPORT-1:0][AAW-1:0] arch;
  logic [NPORT-1:0][PAW-1:0] phys;
  assign arch = {wr_addr_i, rd_b_addr_i, rd_a_addr_i};

  for (genvar i = 0; i < NPORT; i++) begin : g_map
    rw_addr_map #(.NGLOB(NGLOB), .NOUT(NOUT), .NLOC(NLOC), .NWIN(NWIN)) u_map (
      .arch_i(arch[i]), .cwp_i(cwp), .phys_o(phys[i])
    );
  end

  logic [1:0][XLEN-1:0] rdata;
  rw_store #(.XLEN(XLEN), .NPHYS(NPHYS), .NRD(2)) u_store (
    .clk(clk), .we_i(wr_en_i), .waddr_i(phys[2]), .wdata_i(wr_data_i),
    .raddr_i({phys[1], phys[0]}), .rdata_o(rdata)
  );
  assign rd_a_data_o = rdata[0];
  assign rd_b_data_o = rdata[1];

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_s2)
    (rd_a_addr_i == '0) |-> (rd_a_data_o == '0)) else $error("r0 nonzero"); // R1
  AST_FORWARD: assert property (@(posedge clk) disable iff (!rst_s2)
    (wr_en_i && wr_addr_i != '0 && wr_addr_i == rd_b_addr_i) |-> (rd_b_data_o == wr_data_i))
    else $error("no bypass"); // R10
  AST_GLOBAL_STICKY: assert property (@(posedge clk) disable iff (!rst_s2)
    (wr_en_i && wr_addr_i != '0 && int'(wr_addr_i) < NGLOB && call_i && !ovf_trap_o
     && rd_a_addr_i == wr_addr_i) |=> (rd_a_addr_i != $past(rd_a_addr_i) || wr_en_i
     || rd_a_data_o == $past(wr_data_i))) else $error("global moved"); // R2
endmodule

// File: tb/tb_rw_file.sv
module tb_rw_file;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, call_i, ret_i, swp_inc_i, swp_dec_i, wr_en_i, ovf, unf;
  logic [4:0] ra, rb, wa;
  logic [31:0] rda, rdb, wd;
  logic [2:0] cwp, swp;

  rw_file dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .swp_inc_i(swp_inc_i), .swp_dec_i(swp_dec_i),
    .rd_a_addr_i(ra), .rd_a_data_o(rda), .rd_b_addr_i(rb), .rd_b_data_o(rdb),
    .wr_en_i(wr_en_i), .wr_addr_i(wa), .wr_data_i(wd),
    .cwp_o(cwp), .swp_o(swp), .ovf_trap_o(ovf), .unf_trap_o(unf)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;
  int m_cwp, m_swp;
  logic [31:0] m_mem [106];
  bit m_val [106];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int inc6(input int p); return (p == 5) ? 0 : p + 1; endfunction
  function automatic int dec6(input int p); return (p == 0) ? 5 : p - 1; endfunction

  function automatic int bmap(input int a, input int w);
    if (a < 10) return a;
    if (a < 26) return 10 + w * 16 + (a - 10);
    return 10 + inc6(w) * 16 + (a - 26);
  endfunction

  function automatic string rtag(input int a, input bit fwd);
    if (a == 0) return "R1";
    if (fwd)    return "R10";
    if (a < 10) return "R2";
    if (a < 26) return "R3";
    return "R4";
  endfunction

  task automatic chk_read(input int a, input logic [31:0] act);
    int p;
    bit fwd;
    p   = bmap(a, m_cwp);
    fwd = wr_en_i && wa != 0 && bmap(int'(wa), m_cwp) == p;
    if (a == 0)     chk(act, 32'h0, rtag(a, 0));
    else if (fwd)   chk(act, wd, rtag(a, 1));
    else if (m_val[p]) chk(act, m_mem[p], rtag(a, 0));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 106; i++) m_val[i] = 0;
    rst_n = 0; call_i = 0; ret_i = 0; swp_inc_i = 0; swp_dec_i = 0;
    wr_en_i = 0; wa = 0; wd = 0; ra = 0; rb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(32'(cwp), 32'd0, "R11");
    chk(32'(swp), 32'd1, "R11");
    chk(32'(ovf), 32'd0, "R11");
    chk(32'(unf), 32'd0, "R11");
    m_cwp = 0; m_swp = 1;

    // R1: write to r0 then read it back
    @(negedge clk);
    wr_en_i = 1; wa = 0; wd = 32'hdead_beef; ra = 0;
    #1 chk(rda, 32'h0, "R1");
    @(negedge clk);
    wr_en_i = 0;
    #1 chk(rda, 32'h0, "R1");

    for (int i = 0; i < 6000; i++) begin
      int r, ncwp, nswp;
      bit eo, eu;
      @(negedge clk);
      chk(32'(cwp), 32'(m_cwp), "R5");
      chk(32'(swp), 32'(m_swp), "R9");
      r = $urandom % 16;
      call_i    = (r < 4) || (r == 13);
      ret_i     = (r >= 4 && r < 8) || (r == 13) || (r == 14 && i % 2 == 0);
      swp_inc_i = (r == 8) || (r == 9) || (r == 12) || (r == 14);
      swp_dec_i = (r == 10) || (r == 11) || (r == 12) || (r == 15);
      wr_en_i   = ($urandom % 3) != 0;
      wa        = 5'($urandom % 32);
      wd        = $urandom;
      ra        = (($urandom % 4) == 0) ? wa : 5'($urandom % 32);
      rb        = (($urandom % 4) == 0) ? wa : 5'($urandom % 32);
      #1;
      eo = call_i && dec6(m_cwp) == m_swp;
      eu = ret_i && !call_i && inc6(m_cwp) == m_swp;
      chk(32'(ovf), 32'(eo), call_i ? "R6" : "R8");
      chk(32'(unf), 32'(eu), (ret_i && !call_i) ? "R7" : "R8");
      chk_read(int'(ra), rda);
      chk_read(int'(rb), rdb);
      ncwp = m_cwp; nswp = m_swp;
      if (call_i) begin
        if (!eo) ncwp = dec6(m_cwp);
      end else if (ret_i) begin
        if (!eu) ncwp = inc6(m_cwp);
      end else if (swp_inc_i ^ swp_dec_i) begin
        int t;
        t = swp_inc_i ? inc6(m_swp) : dec6(m_swp);
        if (t != m_cwp) nswp = t;
      end
      @(posedge clk);
      if (wr_en_i && wa != 0) begin
        m_mem[bmap(int'(wa), m_cwp)] = wd;
        m_val[bmap(int'(wa), m_cwp)] = 1;
      end
      m_cwp = ncwp; m_swp = nswp;
    end
    @(negedge clk);
    call_i = 0; ret_i = 0; swp_inc_i = 0; swp_dec_i = 0; wr_en_i = 0;
    chk(32'(cwp), 32'(m_cwp), "R5");
    chk(32'(swp), 32'(m_swp), "R9");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule